// File: doc/BRIEF.md
# Programmable Module Clock Generator

This block derives a module clock from one of several source clocks. It divides the selected source in two stages: first by a power of two, then by a linear factor from 1 to 16. It also produces two copies of that divided clock, each retarded by a programmable whole number of source periods. A single 32-bit control word, written and read through a simple register port, holds every setting.

Each source is presented to the block as a tick strobe, synchronous to the fabric clock `clk`. One tick marks one period of that source. All three outputs are registered in the `clk` domain and change only on a tick of the selected source, so the result cannot run faster than that source. A new divider or phase setting takes effect only where the current divided period ends. A change of source passes through a short interval in which all outputs are held low.

Top module: `modclk_gen`

## Requirements
- R1: `rd_data` always shows the last word written through `wr_en`/`wr_data`, one clock after the write; after reset it reads 0.
- R2: With linear field m in bits [3:0] and pre-scale field p in bits [17:16], the divided output period is N = (m+1)·2^p selected-source periods.
- R3: The divided output is high for floor(N/2) source periods and low for the rest of the period; at N = 1 it stays high while enabled.
- R4: The source-select field starts at bit 24 and is SEL_W bits wide (2 by default, 4 as the wide option); value k selects `src_tick[k]`.
- R5: When bit 31 (enable) is 0, all three outputs are low from the next clock onward and the counters restart from the beginning of a period.
- R6: Phase field A in bits [11:8] drives `clk_pha_o` and phase field B in bits [23:20] drives `clk_phb_o`; a nonzero value d yields the divided clock delayed by exactly d source periods.
- R7: A phase value of 0 yields the logical inverse of the divided clock (a half-cycle shift).
- R8: Divider and phase settings written mid-period are applied only when the running divided period completes.
- R9: A change of source, taken at a period boundary, holds all outputs low for two ticks of the old source and then two ticks of the new source before output resumes.
- R10: The outputs change level only on a tick of the selected source, so every high time and period is a whole multiple of that source's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Current control word |
| src_tick | input | 2^SEL_W | One strobe per source; each pulse marks one source period |
| clk_div_o | output | 1 | Divided module clock |
| clk_pha_o | output | 1 | Phase-shifted copy driven by phase field A |
| clk_phb_o | output | 1 | Phase-shifted copy driven by phase field B |

## Verification
The hardest situation to reach from the ports is a settings change that arrives in the middle of a divided period. The bench waits for a rising edge of the divided clock and writes a much shorter ratio on the very next clock. It then measures the high time of the pulse already under way, which must still follow the old ratio. A similar challenge is seeing the source-change gap, because a low phase of the divided clock hides it. The bench therefore sets one phase field to 0, so that outside the gap at least one output is always high. The longest run with all three outputs low then measures the gap directly.

// File: rtl/modclk_pkg.sv
`timescale 1ns/1ps
package modclk_pkg;
  localparam int M_W     = 4;
  localparam int P_W     = 2;
  localparam int PH_W    = 4;
  localparam int M_LSB   = 0;
  localparam int PHA_LSB = 8;
  localparam int P_LSB   = 16;
  localparam int PHB_LSB = 20;
  localparam int SEL_LSB = 24;
  localparam int EN_BIT  = 31;
  localparam int RATIO_MAX = (1 << M_W) << ((1 << P_W) - 1);
  localparam int CNT_W     = $clog2(RATIO_MAX);

  typedef logic [CNT_W:0] ratio_t;

  typedef enum logic [1:0] {SW_OFF, SW_RUN, SW_DRAIN, SW_FILL} sw_state_e;

  // whole divide ratio: linear stage times power-of-two stage
  function automatic ratio_t total_ratio(input logic [M_W-1:0] m, input logic [P_W-1:0] p);
    ratio_t r;
    r = ratio_t'(m) + ratio_t'(1);
    return r << p;
  endfunction

  // number of high slots in one divided period
  function automatic ratio_t high_slots(input ratio_t n);
    return (n == ratio_t'(1)) ? n : (n >> 1);
  endfunction
endpackage

// File: rtl/modclk_src_switch.sv
`timescale 1ns/1ps
module modclk_src_switch
  import modclk_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [SEL_W-1:0]        req_sel,
  input  logic [(1<<SEL_W)-1:0]   src_tick,
  input  logic                    wrap,
  output logic                    tick,
  output logic                    switch_now,
  output logic                    sw_hold,
  output logic                    gating
);
  sw_state_e        st_q;
  logic [SEL_W-1:0] sel_q;
  logic             gcnt_q;

  assign tick       = src_tick[sel_q];
  assign sw_hold    = (st_q != SW_RUN);
  assign gating     = (st_q == SW_DRAIN) || (st_q == SW_FILL);
  assign switch_now = (st_q == SW_RUN) && tick && wrap && (req_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_OFF;
      sel_q  <= '0;
      gcnt_q <= 1'b0;
    end else if (!en) begin
      st_q   <= SW_OFF;
      sel_q  <= req_sel;
      gcnt_q <= 1'b0;
    end else begin
      case (st_q)
        SW_OFF: begin
          st_q  <= SW_RUN;
          sel_q <= req_sel;
        end
        SW_RUN: if (switch_now) begin
          st_q   <= SW_DRAIN;
          gcnt_q <= 1'b0;
        end
        SW_DRAIN: if (tick) begin
          if (gcnt_q) begin
            sel_q  <= req_sel;
            st_q   <= SW_FILL;
            gcnt_q <= 1'b0;
          end else begin
            gcnt_q <= 1'b1;
          end
        end
        SW_FILL: if (tick) begin
          if (gcnt_q) begin
            st_q   <= SW_RUN;
            gcnt_q <= 1'b0;
          end else begin
            gcnt_q <= 1'b1;
          end
        end
        default: st_q <= SW_OFF;
      endcase
    end
  end

  // R9: the old-source drain never jumps straight back to running
  p_drain_to_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_DRAIN) |=> (st_q != SW_RUN));
endmodule

// File: rtl/modclk_div_core.sv
`timescale 1ns/1ps
module modclk_div_core
  import modclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            tick,
  input  logic            kill,
  input  logic [M_W-1:0]  cfg_m,
  input  logic [P_W-1:0]  cfg_p,
  input  logic [PH_W-1:0] cfg_pha,
  input  logic [PH_W-1:0] cfg_phb,
  output logic            lvl,
  output logic            wrap,
  output logic            div_o,
  output logic [M_W-1:0]  act_m,
  output logic [PH_W-1:0] act_pha,
  output logic [PH_W-1:0] act_phb
);
  logic [M_W-1:0]  m_q;
  logic [P_W-1:0]  p_q;
  logic [PH_W-1:0] pha_q, phb_q;
  ratio_t          cnt_q;
  ratio_t          n_cur;
  logic            div_q;
  logic            load;

  assign n_cur   = total_ratio(m_q, p_q);
  assign wrap    = (cnt_q == n_cur - ratio_t'(1));
  assign lvl     = (cnt_q < high_slots(n_cur));
  assign load    = hold || (tick && wrap);
  assign div_o   = div_q;
  assign act_m   = m_q;
  assign act_pha = pha_q;
  assign act_phb = phb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      p_q   <= '0;
      pha_q <= '0;
      phb_q <= '0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      if (load) begin
        m_q   <= cfg_m;
        p_q   <= cfg_p;
        pha_q <= cfg_pha;
        phb_q <= cfg_phb;
      end
      if (hold) begin
        cnt_q <= '0;
        div_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= wrap ? '0 : cnt_q + ratio_t'(1);
        div_q <= lvl && !kill;
      end
    end
  end
endmodule

// File: rtl/modclk_phase_tap.sv
`timescale 1ns/1ps
module modclk_phase_tap
  import modclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            adv,
  input  logic            kill,
  input  logic            lvl,
  input  logic [PH_W-1:0] dly,
  output logic            ph_o
);
  localparam int DEPTH = (1 << PH_W) - 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH:0]   hist;
  logic             tapped;
  logic             ph_q;

  // hist[k] is the divided level k source ticks before the current slot
  assign hist   = {pipe_q, lvl};
  assign tapped = (dly == '0) ? !lvl : hist[dly];
  assign ph_o   = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      ph_q   <= 1'b0;
    end else if (hold) begin
      pipe_q <= '0;
      ph_q   <= 1'b0;
    end else if (adv) begin
      pipe_q <= hist[DEPTH-1:0];
      ph_q   <= tapped && !kill;
    end
  end
endmodule

// File: rtl/modclk_gen.sv
`timescale 1ns/1ps
module modclk_gen
  import modclk_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  input  logic [(1<<SEL_W)-1:0] src_tick,
  output logic                  clk_div_o,
  output logic                  clk_pha_o,
  output logic                  clk_phb_o
);
  localparam int NTAP = 2;

  logic [31:0]     ctrl_q;
  logic            en;
  logic            tick, switch_now, sw_hold, gating;
  logic            core_hold, adv, emit;
  logic            lvl, wrap;
  logic [M_W-1:0]  act_m;
  logic [PH_W-1:0] act_pha, act_phb;
  logic [PH_W-1:0] tap_dly [NTAP];
  logic [NTAP-1:0] tap_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  assign rd_data   = ctrl_q;
  assign en        = ctrl_q[EN_BIT];
  assign core_hold = !en || sw_hold;
  assign adv       = !core_hold && tick;
  assign emit      = adv && !switch_now;

  modclk_src_switch #(.SEL_W(SEL_W)) u_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .req_sel    (ctrl_q[SEL_LSB +: SEL_W]),
    .src_tick   (src_tick),
    .wrap       (wrap),
    .tick       (tick),
    .switch_now (switch_now),
    .sw_hold    (sw_hold),
    .gating     (gating)
  );

  modclk_div_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (core_hold),
    .tick    (tick),
    .kill    (switch_now),
    .cfg_m   (ctrl_q[M_LSB +: M_W]),
    .cfg_p   (ctrl_q[P_LSB +: P_W]),
    .cfg_pha (ctrl_q[PHA_LSB +: PH_W]),
    .cfg_phb (ctrl_q[PHB_LSB +: PH_W]),
    .lvl     (lvl),
    .wrap    (wrap),
    .div_o   (clk_div_o),
    .act_m   (act_m),
    .act_pha (act_pha),
    .act_phb (act_phb)
  );

  assign tap_dly[0] = act_pha;
  assign tap_dly[1] = act_phb;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    modclk_phase_tap u_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (core_hold),
      .adv   (adv),
      .kill  (switch_now),
      .lvl   (lvl),
      .dly   (tap_dly[g]),
      .ph_o  (tap_out[g])
    );
  end

  assign clk_pha_o = tap_out[0];
  assign clk_phb_o = tap_out[1];

  // R5: disabled means all outputs low on the next clock
  p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[EN_BIT] |=> (!clk_div_o && !clk_pha_o && !clk_phb_o));

  // R9: nothing toggles while the source switch is draining or filling
  p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gating |-> (!clk_div_o && !clk_pha_o && !clk_phb_o));

  // R10: while enabled, the divided output moves only on a selected tick
  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q[EN_BIT]) && (clk_div_o != $past(clk_div_o))) |-> $past(tick));

  // R8: the running ratio and phase only change at a period boundary
  p_cfg_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!core_hold) && $past(ctrl_q[EN_BIT]) &&
     ((act_m != $past(act_m)) || (act_pha != $past(act_pha)))) |-> $past(tick && wrap));

  // R7: a zero phase setting gives the complement of the divided clock
  p_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(emit && (act_pha == '0)) |-> (clk_pha_o == !clk_div_o));
endmodule

// File: tb/modclk_gen_tb.sv
`timescale 1ns/1ps
module modclk_gen_tb;
  localparam int NSRC = 4;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] p;
    logic [3:0] m;
    logic [3:0] pa;
    logic [3:0] pb;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 2'd0, 4'd1,  4'd0,  4'd1},
    '{2'd1, 2'd0, 4'd2,  4'd1,  4'd2},
    '{2'd2, 2'd1, 4'd3,  4'd3,  4'd0},
    '{2'd3, 2'd0, 4'd4,  4'd2,  4'd4},
    '{2'd0, 2'd3, 4'd15, 4'd15, 4'd7},
    '{2'd1, 2'd2, 4'd6,  4'd5,  4'd0},
    '{2'd0, 2'd1, 4'd0,  4'd1,  4'd0},
    '{2'd2, 2'd3, 4'd1,  4'd9,  4'd12},
    '{2'd3, 2'd1, 4'd6,  4'd13, 4'd0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, wr_en;
  logic [31:0]     wr_data, rd_data;
  logic [NSRC-1:0] src_tick;
  logic            div_o, pha_o, phb_o;
  int              n_chk, n_bad, cyc;

  modclk_gen #(.SEL_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_tick(src_tick), .clk_div_o(div_o), .clk_pha_o(pha_o), .clk_phb_o(phb_o)
  );

  function automatic int src_per(int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  // control word: enable bit 31, source at 24, phase B at 20, pre-scale at 16, phase A at 8, linear at 0
  function automatic logic [31:0] mkw(int en, int sel, int p, int m, int pa, int pb);
    return (32'(en) << 31) | (32'(sel) << 24) | (32'(pb) << 20) |
           (32'(p) << 16) | (32'(pa) << 8) | 32'(m);
  endfunction

  initial cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int s = 0; s < NSRC; s++) src_tick[s] <= ((cyc % src_per(s)) == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int per, output int hi, output int lag_a, output int lag_b,
                         output int eq_a, output int eq_b);
    logic pd, pa, pb;
    int t, guard;
    per = -1; hi = -1; lag_a = -1; lag_b = -1; eq_a = 0; eq_b = 0;
    pd = div_o;
    for (guard = 0; guard < 3000; guard++) begin
      @(negedge clk);
      if (div_o && !pd) break;
      pd = div_o;
    end
    if (guard == 3000) return;
    t = 0; pd = 1'b1; pa = pha_o; pb = phb_o;
    for (guard = 0; guard < 3000; guard++) begin
      if (pha_o == div_o) eq_a++;
      if (phb_o == div_o) eq_b++;
      @(negedge clk);
      t++;
      if (!div_o && pd && hi < 0) hi = t;
      if (pha_o && !pa && lag_a < 0) lag_a = t;
      if (phb_o && !pb && lag_b < 0) lag_b = t;
      if (div_o && !pd) begin
        per = t;
        break;
      end
      pd = div_o; pa = pha_o; pb = phb_o;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int per, hi, la, lb, ea, eb, s, n, run, best, bad;
    logic [31:0] w;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; n_chk = 0; n_bad = 0;
    repeat (4) @(negedge clk);
    chk(rd_data == 32'd0, "R1 reset readback", int'(rd_data), 0);
    chk(!div_o && !pha_o && !phb_o, "R5 reset outputs", int'({div_o, pha_o, phb_o}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      w = mkw(1, VECS[i].sel, VECS[i].p, VECS[i].m, VECS[i].pa, VECS[i].pb);
      wr(w);
      chk(rd_data == w, "R1 readback", int'(rd_data), int'(w));
      repeat (1500) @(negedge clk);
      measure(per, hi, la, lb, ea, eb);
      s = src_per(VECS[i].sel);
      n = (int'(VECS[i].m) + 1) * (1 << VECS[i].p);
      chk(per == n * s, "R2,R4 period", per, n * s);
      chk(hi == (n / 2) * s, "R3 high time", hi, (n / 2) * s);
      chk((per % s) == 0 && (hi % s) == 0, "R10 tick multiple", per % s + hi % s, 0);
      if (VECS[i].pa == 0) chk(ea == 0, "R7 phase A inverse", ea, 0);
      else chk(la == int'(VECS[i].pa) * s, "R6 phase A lag", la, int'(VECS[i].pa) * s);
      if (VECS[i].pb == 0) chk(eb == 0, "R7 phase B inverse", eb, 0);
      else chk(lb == int'(VECS[i].pb) * s, "R6 phase B lag", lb, int'(VECS[i].pb) * s);
    end

    // ratio 1: divided high, zero phase low, one-period delay high
    wr(mkw(1, 1, 0, 0, 0, 1));
    repeat (300) @(negedge clk);
    bad = 0; ea = 0; eb = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!div_o) bad++;
      if (pha_o) ea++;
      if (!phb_o) eb++;
    end
    chk(bad == 0, "R3 ratio one high", bad, 0);
    chk(ea == 0, "R7 ratio one inverse", ea, 0);
    chk(eb == 0, "R6 ratio one delayed", eb, 0);

    // mid-period write keeps the current pulse on the old ratio
    wr(mkw(1, 0, 0, 15, 1, 1));
    repeat (400) @(negedge clk);
    s = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (div_o && s == 0) break;
      s = div_o ? 1 : 0;
    end
    s = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      wr_en = (k == 0);
      wr_data = mkw(1, 0, 0, 1, 1, 1);
    end
    wr_en = 1'b0;
    repeat (300) @(negedge clk);
    wr(mkw(1, 0, 0, 15, 1, 1));
    repeat (400) @(negedge clk);
    s = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (div_o && s == 0) break;
      s = div_o ? 1 : 0;
    end
    wr_en = 1'b1;
    wr_data = mkw(1, 0, 0, 1, 1, 1);
    hi = -1;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!div_o) begin
        hi = k;
        break;
      end
    end
    chk(hi == 8, "R8 pulse in flight", hi, 8);
    repeat (100) @(negedge clk);
    measure(per, hi, la, lb, ea, eb);
    chk(per == 2, "R8 new ratio applied", per, 2);

    // source change: zero phase A makes any all-low run the switch gap
    wr(mkw(1, 0, 0, 3, 0, 0));
    repeat (300) @(negedge clk);
    best = 0; run = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!div_o && !pha_o && !phb_o) run++; else run = 0;
      if (run > best) best = run;
    end
    chk(best == 0, "R9 no gap while steady", best, 0);
    wr(mkw(1, 3, 0, 3, 0, 0));
    best = 0; run = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!div_o && !pha_o && !phb_o) run++; else run = 0;
      if (run > best) best = run;
    end
    chk(best >= 2 * 1 + 2 * 5, "R9 switch gap", best, 12);
    measure(per, hi, la, lb, ea, eb);
    chk(per == 20, "R4 period after switch", per, 20);

    // disable holds everything low, re-enable restarts
    wr(mkw(0, 3, 0, 3, 0, 0));
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (div_o || pha_o || phb_o) bad++;
    end
    chk(bad == 0, "R5 disabled low", bad, 0);
    chk(rd_data == mkw(0, 3, 0, 3, 0, 0), "R1 readback disabled", int'(rd_data), int'(mkw(0, 3, 0, 3, 0, 0)));
    wr(mkw(1, 2, 0, 2, 1, 2));
    repeat (200) @(negedge clk);
    measure(per, hi, la, lb, ea, eb);
    chk(per == 9, "R5 restart period", per, 9);
    chk(lb == 6, "R6 restart lag", lb, 6);

    summary();
    $finish;
  end
endmodule